// File: doc/BRIEF.md
# Row/Column Block Staging Buffer

This block holds 4x4 pixel blocks between the horizontal and vertical passes of a two-dimensional edge filter. It contains two register arrays of four 32-bit rows, each row carrying four 8-bit pixels. The first array, the staging array, keeps a block in row-major order. A horizontal filter reads a block from it and writes the partly filtered block back, so that the block can join the next horizontal operation.

The second array, the turn array, takes a block that is finished with horizontal work. The block is copied from the staging array one row per cycle over four cycles. The turn array can be read as columns, which gives column-major words to a vertical filter. Results from the vertical filter can be written back one column at a time and then read out as rows. A block therefore returns to row-major order over four cycles.

A copy from the staging array into the turn array may run in the same cycles as a new block is written into the staging array. Each copy takes the contents the staging row held before that clock edge. One block's handoff therefore overlaps the next block's load.

Top module: `blkXposeBuf`

## Requirements
- R1: While rstN is low, every pixel of both arrays is zero, so every read port returns 0.
- R2: A staging write with shWe=1 stores shWrData bits [8c+7:8c] as pixel [shWrRow][c]. shRdData returns row shRdRow with pixel c in bits [8c+7:8c].
- R3: A read of a row or column that is written in the same cycle returns the old contents in that cycle. The new value appears after the clock edge.
- R4: hoEn=1 copies staging row hoRow into turn row hoRow at the clock edge and leaves the staging array unchanged.
- R5: When hoEn and shWe are active in the same cycle, even on the same row, the turn array receives the staging contents from before the edge and the staging array takes the new write.
- R6: With xpRdCol=1, xpRdData returns column xpRdIdx as pixel [r][xpRdIdx] in bits [8r+7:8r] for r = 0..3.
- R7: With xpRdCol=0, xpRdData returns turn row xpRdIdx with pixel c in bits [8c+7:8c].
- R8: A turn write with xpWe=1 and xpWrCol=1 stores xpWrData bits [8r+7:8r] as pixel [r][xpWrIdx] for every r.
- R9: A turn write with xpWe=1 and xpWrCol=0 stores xpWrData bits [8c+7:8c] as pixel [xpWrIdx][c] for every c.
- R10: When a handoff and a turn write hit the same pixel in one cycle, the turn write wins for that pixel. Pixels outside the write still take the handoff data.
- R11: With shWe, hoEn and xpWe all low, neither array changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| shWe | input | 1 | Staging row write enable |
| shWrRow | input | 2 | Staging row written |
| shWrData | input | 32 | Staging write data, pixel 0 in the low byte |
| shRdRow | input | 2 | Staging row read |
| shRdData | output | 32 | Staging row read data |
| hoEn | input | 1 | Copy one staging row into the turn array |
| hoRow | input | 2 | Row index for the copy |
| xpWe | input | 1 | Turn array write enable |
| xpWrCol | input | 1 | 1: write a column, 0: write a row |
| xpWrIdx | input | 2 | Row or column written |
| xpWrData | input | 32 | Turn write data |
| xpRdCol | input | 1 | 1: read a column, 0: read a row |
| xpRdIdx | input | 2 | Row or column read |
| xpRdData | output | 32 | Turn array read data |

## Verification
Both read ports are combinational on the stored arrays, so a read is valid in the cycle its index is applied. Writes, handoffs and their overlaps take effect at the next rising edge and are first visible one cycle after the stimulus. The bench applies stimulus at the falling edge and compares both read ports against a behavioural model shortly afterwards, still before the rising edge. The model is updated only after that edge. This ordering means that reads made in the same cycle as a write are checked against the old contents.

// File: rtl/blkbuf_pkg.sv
package blkbuf_pkg;
  localparam int PIX_W  = 8;
  localparam int DIM    = 4;
  localparam int IDX_W  = $clog2(DIM);
  localparam int WORD_W = PIX_W * DIM;

  typedef logic [DIM-1:0][PIX_W-1:0] word_t;
  typedef logic [DIM-1:0][DIM-1:0][PIX_W-1:0] block_t;

  typedef struct packed {
    logic [DIM-1:0]          shRowWe;
    logic [DIM-1:0]          hoRowSel;
    logic [DIM-1:0][DIM-1:0] xpPixWe;
    logic                    xpColMode;
  } bufStrobes_t;
endpackage

// File: rtl/blkbuf_ctrl.sv
module blkbuf_ctrl
  import blkbuf_pkg::*;
(
  input  logic             shWe,
  input  logic [IDX_W-1:0] shWrRow,
  input  logic             hoEn,
  input  logic [IDX_W-1:0] hoRow,
  input  logic             xpWe,
  input  logic             xpWrCol,
  input  logic [IDX_W-1:0] xpWrIdx,
  output bufStrobes_t      strb
);
  always_comb begin
    strb = '0;
    strb.xpColMode = xpWrCol;
    for (int r = 0; r < DIM; r++) begin
      strb.shRowWe[r]  = shWe && (shWrRow == IDX_W'(r));
      strb.hoRowSel[r] = hoEn && (hoRow == IDX_W'(r));
      for (int c = 0; c < DIM; c++) begin
        strb.xpPixWe[r][c] = xpWe &&
          (xpWrCol ? (xpWrIdx == IDX_W'(c)) : (xpWrIdx == IDX_W'(r)));
      end
    end
  end
endmodule

// File: rtl/blkbuf_dp.sv
module blkbuf_dp
  import blkbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  bufStrobes_t      strb,
  input  word_t            shWrData,
  input  word_t            xpWrData,
  input  logic [IDX_W-1:0] shRdRow,
  input  logic             xpRdCol,
  input  logic [IDX_W-1:0] xpRdIdx,
  output word_t            shRdData,
  output word_t            xpRdData
);
  block_t shMem;
  block_t xpMem;

  for (genvar r = 0; r < DIM; r++) begin : g_row
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shMem[r] <= '0;
      else if (strb.shRowWe[r]) shMem[r] <= shWrData;
    end

    for (genvar c = 0; c < DIM; c++) begin : g_col
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          xpMem[r][c] <= '0;
        end else if (strb.xpPixWe[r][c]) begin
          xpMem[r][c] <= strb.xpColMode ? xpWrData[r] : xpWrData[c];
        end else if (strb.hoRowSel[r]) begin
          xpMem[r][c] <= shMem[r][c];
        end
      end
    end

    // R4: a handoff without a competing write copies the pre-edge staging row
    a_r4_handoff_copy: assert property (@(posedge clk) disable iff (!rstN)
      (strb.hoRowSel[r] && strb.xpPixWe[r] == '0) |=> xpMem[r] == $past(shMem[r]));

    // R2: a staging write lands in the selected row
    a_r2_row_write: assert property (@(posedge clk) disable iff (!rstN)
      strb.shRowWe[r] |=> shMem[r] == $past(shWrData));
  end

  assign shRdData = shMem[shRdRow];

  always_comb begin
    for (int r = 0; r < DIM; r++) begin
      xpRdData[r] = xpRdCol ? xpMem[r][xpRdIdx] : xpMem[xpRdIdx][r];
    end
  end

  // R11: no enable leaves each array unchanged
  a_r11_hold_sh: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shRowWe == '0) |=> $stable(shMem));

  a_r11_hold_xp: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hoRowSel == '0 && strb.xpPixWe == '0) |=> $stable(xpMem));
endmodule

// File: rtl/blkXposeBuf.sv
module blkXposeBuf
  import blkbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              shWe,
  input  logic [IDX_W-1:0]  shWrRow,
  input  logic [WORD_W-1:0] shWrData,
  input  logic [IDX_W-1:0]  shRdRow,
  output logic [WORD_W-1:0] shRdData,
  input  logic              hoEn,
  input  logic [IDX_W-1:0]  hoRow,
  input  logic              xpWe,
  input  logic              xpWrCol,
  input  logic [IDX_W-1:0]  xpWrIdx,
  input  logic [WORD_W-1:0] xpWrData,
  input  logic              xpRdCol,
  input  logic [IDX_W-1:0]  xpRdIdx,
  output logic [WORD_W-1:0] xpRdData
);
  bufStrobes_t strb;
  word_t shRdW, xpRdW;

  blkbuf_ctrl ctrl_i (
    .shWe(shWe), .shWrRow(shWrRow), .hoEn(hoEn), .hoRow(hoRow),
    .xpWe(xpWe), .xpWrCol(xpWrCol), .xpWrIdx(xpWrIdx), .strb(strb)
  );

  blkbuf_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .shWrData(word_t'(shWrData)), .xpWrData(word_t'(xpWrData)),
    .shRdRow(shRdRow), .xpRdCol(xpRdCol), .xpRdIdx(xpRdIdx),
    .shRdData(shRdW), .xpRdData(xpRdW)
  );

  assign shRdData = shRdW;
  assign xpRdData = xpRdW;
endmodule

// File: tb/blkXposeBuf_tb_top.sv
module blkXposeBuf_tb_top;
  logic clk = 0;
  logic rstN = 0;
  logic shWe = 0, hoEn = 0, xpWe = 0, xpWrCol = 0, xpRdCol = 0;
  logic [1:0] shWrRow = 0, shRdRow = 0, hoRow = 0, xpWrIdx = 0, xpRdIdx = 0;
  logic [31:0] shWrData = 0, xpWrData = 0;
  logic [31:0] shRdData, xpRdData;

  int nChk = 0, nFail = 0;
  logic [7:0] shM [4][4];
  logic [7:0] xpM [4][4];

  always #5 clk = ~clk;

  blkXposeBuf dut_i (
    .clk(clk), .rstN(rstN), .shWe(shWe), .shWrRow(shWrRow), .shWrData(shWrData),
    .shRdRow(shRdRow), .shRdData(shRdData), .hoEn(hoEn), .hoRow(hoRow),
    .xpWe(xpWe), .xpWrCol(xpWrCol), .xpWrIdx(xpWrIdx), .xpWrData(xpWrData),
    .xpRdCol(xpRdCol), .xpRdIdx(xpRdIdx), .xpRdData(xpRdData)
  );

  function automatic logic [31:0] expSh();
    logic [31:0] v;
    for (int c = 0; c < 4; c++) v[c*8 +: 8] = shM[shRdRow][c];
    return v;
  endfunction

  function automatic logic [31:0] expXp();
    logic [31:0] v;
    for (int k = 0; k < 4; k++)
      v[k*8 +: 8] = xpRdCol ? xpM[k][xpRdIdx] : xpM[xpRdIdx][k];
    return v;
  endfunction

  task automatic compare(string tag);
    logic [31:0] es, ex;
    es = expSh(); ex = expXp();
    nChk++;
    if (shRdData !== es) begin
      nFail++;
      $display("FAIL %s staging read: actual %h expected %h", tag, shRdData, es);
    end
    nChk++;
    if (xpRdData !== ex) begin
      nFail++;
      $display("FAIL %s turn read: actual %h expected %h", tag, xpRdData, ex);
    end
  endtask

  // inputs already set (at negedge); check reads, clock, update model
  task automatic step(string tag);
    logic [7:0] nx [4][4];
    #1 compare(tag);
    @(posedge clk);
    nx = xpM;
    if (hoEn) for (int c = 0; c < 4; c++) nx[hoRow][c] = shM[hoRow][c];
    if (xpWe) for (int k = 0; k < 4; k++) begin
      if (xpWrCol) nx[k][xpWrIdx] = xpWrData[k*8 +: 8];
      else         nx[xpWrIdx][k] = xpWrData[k*8 +: 8];
    end
    if (shWe) for (int c = 0; c < 4; c++) shM[shWrRow][c] = shWrData[c*8 +: 8];
    xpM = nx;
    @(negedge clk);
    shWe = 0; hoEn = 0; xpWe = 0;
  endtask

  initial begin
    #(200000 * 10);
    nFail++; nChk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) begin
      shM[r][c] = 0; xpM[r][c] = 0;
    end
    @(negedge clk);
    // R1: reset state on every row and column
    for (int i = 0; i < 4; i++) begin
      shRdRow = 2'(i); xpRdIdx = 2'(i); xpRdCol = i[0];
      #1 compare("R1");
      @(negedge clk);
    end
    rstN = 1;
    @(negedge clk);

    // R2/R3: load block A, reading the row being written
    for (int r = 0; r < 4; r++) begin
      shWe = 1; shWrRow = 2'(r); shWrData = 32'h10203040 + 32'h01010101 * r;
      shRdRow = 2'(r);
      step("R3");
      step("R2");
    end
    // R11: idle cycles leave the arrays unchanged
    for (int r = 0; r < 4; r++) begin shRdRow = 2'(r); step("R11"); end

    // R4/R5: hand off A while loading block B into the same rows
    for (int r = 0; r < 4; r++) begin
      hoEn = 1; hoRow = 2'(r);
      shWe = 1; shWrRow = 2'(r); shWrData = 32'hA0B0C0D0 ^ (32'h11 << (8*r));
      shRdRow = 2'(r); xpRdCol = 0; xpRdIdx = 2'(r);
      step("R5");
      step("R4");
    end
    // R6/R7: column and row reads of the turn array
    for (int i = 0; i < 4; i++) begin
      xpRdCol = 1; xpRdIdx = 2'(i); step("R6");
      xpRdCol = 0; step("R7");
    end
    // R8: column writes, read back as rows and columns
    for (int c = 0; c < 4; c++) begin
      xpWe = 1; xpWrCol = 1; xpWrIdx = 2'(c); xpWrData = 32'h5A6B7C8D + c;
      xpRdCol = 1; xpRdIdx = 2'(c);
      step("R8");
      step("R8");
    end
    for (int r = 0; r < 4; r++) begin xpRdCol = 0; xpRdIdx = 2'(r); step("R8"); end
    // R9: row write
    xpWe = 1; xpWrCol = 0; xpWrIdx = 2; xpWrData = 32'hCAFE1234;
    xpRdCol = 0; xpRdIdx = 2;
    step("R9"); step("R9");
    // R10: handoff with overlapping row write (write wins on the whole row)
    hoEn = 1; hoRow = 1; xpWe = 1; xpWrCol = 0; xpWrIdx = 1; xpWrData = 32'h0F1E2D3C;
    xpRdIdx = 1; step("R10"); step("R10");
    // R10: handoff with a column write crossing the row (one pixel overlaps)
    hoEn = 1; hoRow = 3; xpWe = 1; xpWrCol = 1; xpWrIdx = 2; xpWrData = 32'h99887766;
    xpRdCol = 0; xpRdIdx = 3; step("R10"); step("R10");
    xpRdCol = 1; xpRdIdx = 2; step("R10");
    for (int r = 0; r < 4; r++) begin
      shRdRow = 2'(r); xpRdCol = 0; xpRdIdx = 2'(r); step("R11");
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule